// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures the period of a fan's tachometer signal. It has two independent channels, A and B. Each channel has a 16-bit down-counter. The counter steps once per tick, and the ticks come from a clock divider shared by both channels. When a rising edge arrives on a channel's tach input, the block stores the running count in that channel's capture register and raises a capture flag. If the counter first falls to the channel's timeout compare value, the block raises a timeout flag instead. Either event freezes the channel until software rewrites its counter.

Software presets each counter and capture register to 0xFFFF. It loads the timeout compare register with 0xFFFF minus the longest period it will accept (0xFFFF - 0x5000 is a typical value). It then starts counting through the run register. After a valid capture, the number of ticks in one tach period is 0xFFFF minus the captured value. The fan gives two tach pulses per revolution, and the conversion from period to speed is done outside this block. The four event flags appear in one status byte. They are cleared by writing ones to the clear register. Each flag is gated by its enable bit onto a single interrupt line.

The register port takes halfword accesses at even addresses and uses byte enables for partial writes. Read data is combinational on the address.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, the counter, capture and compare registers of both channels read 0xFFFF. The prescaler, run, status and enable registers read 0, and `irq` is low.
- R2: Halfword registers sit at these offsets: A counter 0x00, A capture 0x02, A compare 0x04, B counter 0x06, B capture 0x08, B compare 0x0A. Byte registers sit at: prescaler 0x0C, run 0x0E, status 0x10, clear 0x12, enable 0x14. `reg_be[0]` writes bits 7:0 and `reg_be[1]` writes bits 15:8. Byte registers use lane 0 only.
- R3: A running counter decrements once every P+1 clocks, where P is the prescaler value. The first decrement comes P+1 clocks after the run write takes effect. The divider phase restarts whenever no channel is counting.
- R4: Run register bit 0 enables channel A and bit 3 enables channel B. The other bits are not stored and read back 0. Clearing an enable bit stops the counter and holds its value.
- R5: A rising edge on `tach_in[0]` (A) or `tach_in[1]` (B) passes through a two-flop synchroniser. It then copies the running count into the capture register and sets status bit 0 (A) or bit 1 (B). If the tach line rises just after the clock edge d-3 clocks after the run write takes effect, the stored value is start - floor((d-1)/(P+1)).
- R6: When a counting channel's count equals its compare value, status bit 4 (A) or bit 5 (B) is set one clock later, and the counter stays at the compare value.
- R7: After a capture or a timeout, the channel ignores further tach edges and timeouts and does not count. A write to its counter register restarts it from the written value if its run bit is set. A capture and a timeout in the same clock resolve to the capture.
- R8: Writing to the clear register clears each status bit whose written bit is 1 and leaves the others unchanged. An event arriving in the same clock wins over the clear.
- R9: `irq` is high exactly when some status bit and the matching bit of the enable register (bits 5:0) are both 1.
- R10: Status bits 2 and 3 always read 0. Writes to the status offset change nothing.
- R11: Tach edges on a channel whose run bit is clear leave its capture register and status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address, halfword aligned; odd addresses are ignored |
| reg_be | input | 2 | Byte lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tach_in | input | 2 | Tachometer inputs, bit 0 = A, bit 1 = B |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit counters, an 8-bit prescaler and a two-flop tach synchroniser. It programs prescaler values of 0 to 3, so that many ticks fit in a short run. This puts the exact capture formula, the precise clock on which a timeout appears and the divider's phase restart within reach. Random start values, edge delays, channels and enable masks are mixed with directed cases. The directed cases are a timeout where start equals compare, edges arriving after an event, edges while stopped, partial byte writes and clear-mask selectivity.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int unsigned NCH     = 2;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned FLAG_W  = 6;
  localparam int unsigned CH_STRIDE = 6;

  localparam logic [REG_AW-1:0] OFS_PRESCALE = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RUN      = 5'h0E;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CLEAR    = 5'h12;
  localparam logic [REG_AW-1:0] OFS_ENABLE   = 5'h14;

  // k: 0 counter, 1 capture, 2 compare
  function automatic logic [REG_AW-1:0] chan_ofs(input int ch, input int k);
    return REG_AW'(ch * CH_STRIDE + 2 * k);
  endfunction

  function automatic int run_pos(input int ch);
    return ch * 3;
  endfunction

  function automatic int cap_pos(input int ch);
    return ch;
  endfunction

  function automatic int tmo_pos(input int ch);
    return 4 + ch;
  endfunction
endpackage

// File: rtl/tach_rst_sync.sv
module tach_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R5
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q, phase_d;
  logic             wrap;

  assign wrap = (phase_q >= limit);
  assign tick = active & wrap;

  always_comb begin
    if (!active)   phase_d = '0;
    else if (wrap) phase_d = '0;
    else           phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0));
endmodule

// File: rtl/tach_channel.sv
module tach_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             rise,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             cap_we,
  input  logic [CNT_W-1:0] cap_wd,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cap_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             evt_cap,
  output logic             evt_tmo,
  output logic             active
);
  logic [CNT_W-1:0] cnt_d, cap_d, cmp_d;
  logic             done_q, done_d;
  logic             step;

  assign active  = run & ~done_q;
  assign evt_cap = active & rise & ~cnt_we;
  assign evt_tmo = active & ~rise & ~cnt_we & (cnt_q == cmp_q);
  assign step    = active & tick & ~evt_cap & ~evt_tmo;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)    cnt_d = cnt_wd;
    else if (step) cnt_d = cnt_q - 1'b1;

    done_d = done_q;
    if (cnt_we)                  done_d = 1'b0;
    else if (evt_cap || evt_tmo) done_d = 1'b1;

    cap_d = cap_q;
    if (evt_cap)     cap_d = cnt_q;
    else if (cap_we) cap_d = cap_wd;

    cmp_d = cmp_we ? cmp_wd : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      cap_q  <= '1;
      cmp_q  <= '1;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      cmp_q  <= cmp_d;
      done_q <= done_d;
    end
  end

  // R5
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> (cap_q == $past(cnt_q)));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cnt_we) |=> $stable(cnt_q));

  // R6
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tmo && !cmp_we) |=> (cnt_q == cmp_q));
endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer
  import tach_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [CNT_W/8-1:0]   reg_be,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]       tach_in,
  output logic                 irq
);
  localparam int unsigned BE_W = CNT_W / 8;

  logic rst_q;
  logic wr_en, lane0;

  logic [CNT_W-1:0] cnt_q [NCH];
  logic [CNT_W-1:0] cap_q [NCH];
  logic [CNT_W-1:0] cmp_q [NCH];
  logic [NCH-1:0]   evt_cap, evt_tmo, act, rise;
  logic             tick;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [NCH-1:0]    run_q, run_d;
  logic [FLAG_W-1:0] en_q, en_d;
  logic [NCH-1:0]    capf_q, capf_d, tmof_q, tmof_d;
  logic [FLAG_W-1:0] status, clr_bits;
  logic              clr_wr;

  function automatic logic [CNT_W-1:0] lane_merge(
    input logic [CNT_W-1:0] old_v,
    input logic [CNT_W-1:0] new_v,
    input logic [BE_W-1:0]  be
  );
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction

  tach_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  assign wr_en = reg_sel & reg_wr & ~reg_addr[0];
  assign lane0 = reg_be[0];

  tach_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_q),
    .active (|act),
    .limit  (pre_q),
    .tick   (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic cnt_we, cap_we, cmp_we;

    assign cnt_we = wr_en && (reg_addr == chan_ofs(c, 0));
    assign cap_we = wr_en && (reg_addr == chan_ofs(c, 1));
    assign cmp_we = wr_en && (reg_addr == chan_ofs(c, 2));

    tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_q),
      .din   (tach_in[c]),
      .rise  (rise[c])
    );

    tach_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_q),
      .run     (run_q[c]),
      .tick    (tick),
      .rise    (rise[c]),
      .cnt_we  (cnt_we),
      .cnt_wd  (lane_merge(cnt_q[c], reg_wdata, reg_be)),
      .cap_we  (cap_we),
      .cap_wd  (lane_merge(cap_q[c], reg_wdata, reg_be)),
      .cmp_we  (cmp_we),
      .cmp_wd  (lane_merge(cmp_q[c], reg_wdata, reg_be)),
      .cnt_q   (cnt_q[c]),
      .cap_q   (cap_q[c]),
      .cmp_q   (cmp_q[c]),
      .evt_cap (evt_cap[c]),
      .evt_tmo (evt_tmo[c]),
      .active  (act[c])
    );
  end

  // control and flag next state
  assign clr_wr   = wr_en & lane0 & (reg_addr == OFS_CLEAR);
  assign clr_bits = clr_wr ? reg_wdata[FLAG_W-1:0] : '0;

  always_comb begin
    pre_d = pre_q;
    if (wr_en && lane0 && reg_addr == OFS_PRESCALE) pre_d = reg_wdata[PRE_W-1:0];

    en_d = en_q;
    if (wr_en && lane0 && reg_addr == OFS_ENABLE) en_d = reg_wdata[FLAG_W-1:0];

    run_d = run_q;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && lane0 && reg_addr == OFS_RUN) run_d[c] = reg_wdata[run_pos(c)];
      capf_d[c] = evt_cap[c] | (capf_q[c] & ~clr_bits[cap_pos(c)]);
      tmof_d[c] = evt_tmo[c] | (tmof_q[c] & ~clr_bits[tmo_pos(c)]);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pre_q  <= '0;
      en_q   <= '0;
      run_q  <= '0;
      capf_q <= '0;
      tmof_q <= '0;
    end else begin
      pre_q  <= pre_d;
      en_q   <= en_d;
      run_q  <= run_d;
      capf_q <= capf_d;
      tmof_q <= tmof_d;
    end
  end

  always_comb begin
    status = '0;
    for (int c = 0; c < NCH; c++) begin
      status[cap_pos(c)] = capf_q[c];
      status[tmo_pos(c)] = tmof_q[c];
    end
  end

  assign irq = |(status & en_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[0]) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == chan_ofs(c, 0)) reg_rdata = cnt_q[c];
        if (reg_addr == chan_ofs(c, 1)) reg_rdata = cap_q[c];
        if (reg_addr == chan_ofs(c, 2)) reg_rdata = cmp_q[c];
        if (reg_addr == OFS_RUN)        reg_rdata[run_pos(c)] = run_q[c];
      end
      if (reg_addr == OFS_PRESCALE) reg_rdata = CNT_W'(pre_q);
      if (reg_addr == OFS_STATUS)   reg_rdata = CNT_W'(status);
      if (reg_addr == OFS_ENABLE)   reg_rdata = CNT_W'(en_q);
    end
  end

  // R6
  tmo_flag_a_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evt_tmo[0] |=> tmof_q[0]);

  // R6
  tmo_flag_b_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evt_tmo[1] |=> tmof_q[1]);

  // R8
  clear_tmo_a_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (clr_wr && reg_wdata[tmo_pos(0)] && !evt_tmo[0]) |=> !tmof_q[0]);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> (en_q != '0));
endmodule

// File: tb/tach_capture_timer_tb.sv
`timescale 1ns/100ps
module tach_capture_timer_tb;
  localparam logic [4:0] A_CNT = 5'h00, A_CAP = 5'h02, A_CMP = 5'h04;
  localparam logic [4:0] B_CNT = 5'h06, B_CAP = 5'h08, B_CMP = 5'h0A;
  localparam logic [4:0] PRE = 5'h0C, RUN = 5'h0E, STAT = 5'h10, CLR = 5'h12, ENA = 5'h14;

  logic        clk, rst_n, reg_sel, reg_wr, irq;
  logic [4:0]  reg_addr;
  logic [1:0]  reg_be, tach_in;
  logic [15:0] reg_wdata, reg_rdata;
  int          total, bad;

  tach_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tach_in(tach_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_cap(input logic [15:0] s, input int p, input int d);
    return s - 16'((d - 1) / (p + 1));
  endfunction

  function automatic logic [4:0] cnt_of(input int ch); return ch ? B_CNT : A_CNT; endfunction
  function automatic logic [4:0] cap_of(input int ch); return ch ? B_CAP : A_CAP; endfunction
  function automatic logic [4:0] cmp_of(input int ch); return ch ? B_CMP : A_CMP; endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] a, input logic [15:0] exp);
    reg_addr = a;
    #0.1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic prep(input int ch, input logic [15:0] s, input logic [15:0] c, input int p);
    wr(RUN, 16'h0000);
    wr(cnt_of(ch), s);
    wr(cap_of(ch), 16'hFFFF);
    wr(cmp_of(ch), c);
    wr(PRE, 16'(p));
    wr(CLR, 16'h003F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_be = '0; reg_wdata = '0; tach_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_reg("R1 A cnt", A_CNT, 16'hFFFF);
    chk_reg("R1 A cap", A_CAP, 16'hFFFF);
    chk_reg("R1 B cmp", B_CMP, 16'hFFFF);
    chk_reg("R1 prescale", PRE, 16'h0000);
    chk_reg("R1 run", RUN, 16'h0000);
    chk_reg("R1 status", STAT, 16'h0000);
    chk_reg("R1 enable", ENA, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 byte lanes
    wr(A_CMP, 16'h1234);
    wr(A_CMP, 16'h99AB, 2'b01);
    chk_reg("R2 low lane", A_CMP, 16'h12AB);
    wr(A_CMP, 16'h56EE, 2'b10);
    chk_reg("R2 high lane", A_CMP, 16'h56AB);
    wr(B_CAP, 16'hBEEF);
    chk_reg("R2 halfword", B_CAP, 16'hBEEF);

    // R3 tick rate, P=3
    prep(0, 16'd100, 16'd0, 3);
    wr(RUN, 16'h0001);
    repeat (39) @(negedge clk);
    chk_reg("R3 before tenth tick", A_CNT, 16'd91);
    @(negedge clk);
    chk_reg("R3 tenth tick", A_CNT, 16'd90);

    // R4 stop and hold, unused run bits
    wr(RUN, 16'h0000);
    repeat (20) @(negedge clk);
    chk_reg("R4 held", A_CNT, 16'd90);
    wr(RUN, 16'h00F6);
    chk_reg("R4 other bits", RUN, 16'h0000);
    repeat (10) @(negedge clk);
    chk_reg("R4 still held", A_CNT, 16'd90);
    wr(RUN, 16'h00FF);
    chk_reg("R4 readback", RUN, 16'h0009);
    wr(RUN, 16'h0000);

    // R6 timeout timing on A: S=0x10, C=0x0C, P=1 -> reaches C after 8 clocks
    prep(0, 16'h0010, 16'h000C, 1);
    wr(ENA, 16'h0010);
    wr(RUN, 16'h0001);
    repeat (8) @(negedge clk);
    chk_reg("R6 no flag yet", STAT, 16'h0000);
    chk_reg("R6 count at compare", A_CNT, 16'h000C);
    @(negedge clk);
    chk_reg("R6 timeout flag A", STAT, 16'h0010);
    chk("R9 irq on timeout", {15'd0, irq}, 16'h0001);
    repeat (6) @(negedge clk);
    chk_reg("R6 held at compare", A_CNT, 16'h000C);

    // R7 edge after timeout ignored
    tach_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk_reg("R7 capture untouched", A_CAP, 16'hFFFF);
    chk_reg("R7 status unchanged", STAT, 16'h0010);

    // R8 selective clear
    wr(CLR, 16'h002F);
    chk_reg("R8 other bits no effect", STAT, 16'h0010);
    wr(CLR, 16'h0010);
    chk_reg("R8 cleared", STAT, 16'h0000);
    chk("R9 irq low after clear", {15'd0, irq}, 16'h0000);

    // R7 reload restarts: tach low first, then write counter while running
    tach_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    wr(A_CNT, 16'h0040);
    repeat (7) @(negedge clk);
    tach_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk_reg("R7 capture after reload", A_CAP, exp_cap(16'h0040, 1, 10));
    chk_reg("R7 status capture", STAT, 16'h0001);
    tach_in[0] = 1'b0;
    wr(RUN, 16'h0000);
    repeat (5) @(negedge clk);

    // R6 timeout on B with start equal to compare
    prep(1, 16'd5, 16'd5, 0);
    wr(RUN, 16'h0008);
    chk_reg("R6 B not yet", STAT, 16'h0000);
    @(negedge clk);
    chk_reg("R6 B timeout flag", STAT, 16'h0020);
    chk_reg("R6 B count", B_CNT, 16'd5);

    // R10 status writes ignored
    wr(STAT, 16'h00FF);
    chk_reg("R10 status write ignored", STAT, 16'h0020);

    // R11 edges while stopped
    prep(0, 16'h0200, 16'h0000, 0);
    tach_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk_reg("R11 capture untouched", A_CAP, 16'hFFFF);
    chk_reg("R11 status clear", STAT, 16'h0000);
    chk_reg("R11 count untouched", A_CNT, 16'h0200);
    tach_in[0] = 1'b0;
    repeat (5) @(negedge clk);

    // R5 R9 R10 random captures
    void'($urandom(32'd20240611));
    for (int t = 0; t < 24; t++) begin
      automatic int          ch = int'($urandom % 2);
      automatic int          p  = int'($urandom % 4);
      automatic int          n  = int'($urandom % 50);
      automatic logic [15:0] s  = 16'h0100 + 16'($urandom % 16'hFE00);
      automatic logic [15:0] en = 16'($urandom % 64);
      automatic logic [15:0] st;
      automatic logic [15:0] ec;
      st = ch ? 16'h0002 : 16'h0001;
      ec = exp_cap(s, p, n + 3);
      prep(ch, s, 16'h0000, p);
      wr(ENA, en);
      wr(RUN, ch ? 16'h0008 : 16'h0001);
      repeat (n) @(negedge clk);
      tach_in[ch] = 1'b1;
      repeat (6) @(negedge clk);
      chk_reg("R5 captured value", cap_of(ch), ec);
      chk_reg("R7 counter frozen at capture", cnt_of(ch), ec);
      chk_reg("R5 R10 status", STAT, st);
      chk("R9 irq mask", {15'd0, irq}, {15'd0, |(st & en)});
      tach_in[ch] = 1'b0;
      wr(RUN, 16'h0000);
      repeat (4) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule